// File: doc/BRIEF.md
# Command/indication channel debouncer

This block serves the command/indication slot that recurs once in every serial frame. On the transmit side the host writes a code into a register. The block drives that code onto the slot output in every frame and keeps doing so until the host writes a new one. On the receive side the block samples the incoming slot once per frame, on a single-cycle frame strobe. It compares each sample with the last value it accepted. A change is taken only after the same new value has been seen in two frames in a row.

An accepted value is latched into a register the host can read, and an interrupt flag is set. The flag can be masked and stays pending until the host clears it. Frame alignment and bit clocking happen outside the block: the strobe marks the cycle in which `rx_slot` holds a complete slot value.

The host port is a simple synchronous register port. Writes take effect on the clock edge and reads are combinational. Address 0 holds the transmit code (read/write). Address 1 holds the accepted receive code (read-only). Address 2 is control: bit 0 is the interrupt enable and bit 1 is the pending flag, which is cleared by writing a one. Address 3 reads as zero. Codes are zero-extended to the data width.

Top module: `ci_debouncer`

## Requirements
- R1: After reset, `tx_slot` and the transmit register (address 0) read all ones, the accepted register (address 1) reads all ones, the control register (address 2) reads zero, and `irq` is 0.
- R2: A host write to address 0 appears on `tx_slot`, and on readback of address 0, from the cycle after the write.
- R3: `tx_slot` keeps its value across any number of frames and any receive activity until address 0 is written again.
- R4: A value that differs from the accepted value but appears in only one frame is not accepted: address 1 and the pending flag are unchanged.
- R5: When a value that differs from the accepted value appears in two successive strobed frames, it is readable at address 1 from the cycle after the second strobe, and the pending flag (address 2 bit 1) is set in that same cycle.
- R6: If a candidate value is followed in the next frame by a different non-accepted value, the first value is dropped and the second becomes the candidate, so the second is accepted on its next repetition.
- R7: A frame carrying the currently accepted value produces no acceptance and no interrupt, and it drops any pending candidate.
- R8: `irq` equals the pending flag gated by the enable bit (address 2 bit 0). A masked acceptance still sets the pending flag, and enabling the interrupt later raises `irq`.
- R9: The pending flag stays set until the host writes 1 to address 2 bit 1. Writing 0 to that bit, or further acceptances, leave it set. An acceptance in the same cycle as a clear leaves it set.
- R10: Slot data is looked at only in strobed cycles: changes of `rx_slot` without `slot_stb` neither count as a frame nor disturb the candidate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_stb | input | 1 | One-cycle strobe per frame; rx_slot is valid in this cycle |
| rx_slot | input | CODE_W | Received slot code |
| tx_slot | output | CODE_W | Code to transmit in every frame |
| host_we | input | 1 | Host write enable |
| host_addr | input | 2 | Host register address |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Host read data (combinational) |
| irq | output | 1 | Maskable interrupt request |

## Verification
The receive side is driven with several frame patterns. A lone glitch frame followed by the old value must not be accepted. A clean double repeat must be accepted. A candidate is replaced by a different value and that value is then repeated. A candidate is interrupted by the accepted value. Slot data is toggled between strobes. Together these patterns separate a correct two-frame confirmation from designs that accept on the first frame, never replace a candidate, keep a candidate across an equal frame, or sample without the strobe. Masked acceptances, clears with a written zero, and a clear that lands in the same cycle as an acceptance separate the pending-flag and enable behaviour. A behavioural model compared every clock covers the transmit register under all of this traffic.

// File: rtl/ci_debouncer_pkg.sv
package ci_debouncer_pkg;
  localparam logic [1:0] ADDR_TX   = 2'd0;
  localparam logic [1:0] ADDR_RX   = 2'd1;
  localparam logic [1:0] ADDR_CTRL = 2'd2;
  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_PEND_BIT = 1;

  typedef enum logic [1:0] {
    RX_DROP      = 2'd0,
    RX_CANDIDATE = 2'd1,
    RX_ACCEPT    = 2'd2
  } rx_action_e;

  // Decide what one strobed frame does to the confirmation state.
  function automatic rx_action_e classify(input logic [31:0] sample,
                                          input logic [31:0] accepted,
                                          input logic [31:0] cand,
                                          input logic        cand_vld);
    if (sample == accepted)              return RX_DROP;
    else if (cand_vld && sample == cand) return RX_ACCEPT;
    else                                 return RX_CANDIDATE;
  endfunction
endpackage

// File: rtl/ci_rx_confirm.sv
module ci_rx_confirm
  import ci_debouncer_pkg::*;
#(
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_stb,
  input  logic [CODE_W-1:0] rx_slot,
  output logic [CODE_W-1:0] accepted_code,
  output logic              accept_evt
);
  localparam logic [CODE_W-1:0] CODE_ONES = '1;

  logic [CODE_W-1:0] acc_q, cand_q;
  logic              cand_vld_q;
  rx_action_e        action;

  always_comb begin
    action = classify(32'(rx_slot), 32'(acc_q), 32'(cand_q), cand_vld_q);
  end

  assign accept_evt    = slot_stb && (action == RX_ACCEPT);
  assign accepted_code = acc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q      <= CODE_ONES;
      cand_q     <= '0;
      cand_vld_q <= 1'b0;
    end else if (slot_stb) begin
      case (action)
        RX_ACCEPT: begin
          acc_q      <= rx_slot;
          cand_vld_q <= 1'b0;
        end
        RX_CANDIDATE: begin
          cand_q     <= rx_slot;
          cand_vld_q <= 1'b1;
        end
        default: cand_vld_q <= 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/ci_host_regs.sv
module ci_host_regs
  import ci_debouncer_pkg::*;
#(
  parameter int CODE_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [1:0]        host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              accept_evt,
  input  logic [CODE_W-1:0] accepted_code,
  output logic [CODE_W-1:0] tx_code,
  output logic              pending,
  output logic              irq_en
);
  localparam logic [CODE_W-1:0] CODE_ONES = '1;

  logic wr_tx, wr_ctrl, clr_req;
  logic unused_wdata;

  assign wr_tx   = host_we && (host_addr == ADDR_TX);
  assign wr_ctrl = host_we && (host_addr == ADDR_CTRL);
  assign clr_req = wr_ctrl && host_wdata[CTRL_PEND_BIT];
  assign unused_wdata = ^host_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_code <= CODE_ONES;
      irq_en  <= 1'b0;
      pending <= 1'b0;
    end else begin
      if (wr_tx)   tx_code <= host_wdata[CODE_W-1:0];
      if (wr_ctrl) irq_en  <= host_wdata[CTRL_EN_BIT];
      if (accept_evt)   pending <= 1'b1;
      else if (clr_req) pending <= 1'b0;
    end
  end

  always_comb begin
    host_rdata = '0;
    case (host_addr)
      ADDR_TX:   host_rdata[CODE_W-1:0] = tx_code;
      ADDR_RX:   host_rdata[CODE_W-1:0] = accepted_code;
      ADDR_CTRL: begin
        host_rdata[CTRL_EN_BIT]   = irq_en;
        host_rdata[CTRL_PEND_BIT] = pending;
      end
      default: host_rdata = '0;
    endcase
  end
endmodule

// File: rtl/ci_debouncer.sv
module ci_debouncer #(
  parameter int CODE_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_stb,
  input  logic [CODE_W-1:0] rx_slot,
  output logic [CODE_W-1:0] tx_slot,
  input  logic              host_we,
  input  logic [1:0]        host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              irq
);
  logic [CODE_W-1:0] accepted_code;
  logic [CODE_W-1:0] tx_code;
  logic              accept_evt;
  logic              pending;
  logic              irq_en;

  ci_rx_confirm #(.CODE_W(CODE_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .slot_stb(slot_stb), .rx_slot(rx_slot),
    .accepted_code(accepted_code), .accept_evt(accept_evt)
  );

  ci_host_regs #(.CODE_W(CODE_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .accept_evt(accept_evt), .accepted_code(accepted_code),
    .tx_code(tx_code), .pending(pending), .irq_en(irq_en)
  );

  assign tx_slot = tx_code;
  assign irq     = pending && irq_en;
endmodule

// File: rtl/ci_debouncer_chk.sv
module ci_debouncer_chk #(
  parameter int CODE_W = 6,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              slot_stb,
  input logic [CODE_W-1:0] rx_slot,
  input logic [CODE_W-1:0] tx_slot,
  input logic              host_we,
  input logic [1:0]        host_addr,
  input logic [DATA_W-1:0] host_wdata,
  input logic              irq,
  input logic              accept_evt,
  input logic [CODE_W-1:0] accepted_code,
  input logic              pending
);
  logic clr_wr, tx_wr;
  assign clr_wr = host_we && host_addr == 2'd2 && host_wdata[1];
  assign tx_wr  = host_we && host_addr == 2'd0;

  a_r5_accept_latches: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> (accepted_code == $past(rx_slot) && pending));

  a_r4_hold_without_accept: assert property (@(posedge clk) disable iff (!rst_n)
    !accept_evt |=> $stable(accepted_code));

  a_r7_equal_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_stb && rx_slot == accepted_code) |-> !accept_evt);

  a_r10_no_strobe_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_stb |-> !accept_evt);

  a_r9_pending_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !clr_wr) |=> pending);

  a_r3_tx_steady: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_wr |=> $stable(tx_slot));

  a_r8_irq_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> pending);
endmodule

bind ci_debouncer ci_debouncer_chk #(.CODE_W(CODE_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .slot_stb(slot_stb), .rx_slot(rx_slot),
  .tx_slot(tx_slot), .host_we(host_we), .host_addr(host_addr),
  .host_wdata(host_wdata), .irq(irq), .accept_evt(accept_evt),
  .accepted_code(accepted_code), .pending(pending)
);

// File: tb/ci_debouncer_bench.sv
`timescale 1ns/1ps
module ci_debouncer_bench;
  localparam int CODE_W = 6;
  localparam int DATA_W = 8;
  localparam int ONES   = (1 << CODE_W) - 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              slot_stb = 1'b0;
  logic [CODE_W-1:0] rx_slot = '0;
  logic [CODE_W-1:0] tx_slot;
  logic              host_we = 1'b0;
  logic [1:0]        host_addr = 2'd0;
  logic [DATA_W-1:0] host_wdata = '0;
  logic [DATA_W-1:0] host_rdata;
  logic              irq;

  always #2.5 clk = ~clk;

  ci_debouncer #(.CODE_W(CODE_W), .DATA_W(DATA_W)) u_ci_debouncer (
    .clk(clk), .rst_n(rst_n), .slot_stb(slot_stb), .rx_slot(rx_slot),
    .tx_slot(tx_slot), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq)
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;
  string cur_req = "R1";

  // behavioural reference state
  int m_tx, m_acc, m_pend, m_en;
  int cand_q[$];

  task automatic check(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic int model_read(int a);
    case (a)
      0: return m_tx;
      1: return m_acc;
      2: return m_en + 2 * m_pend;
      default: return 0;
    endcase
  endfunction

  // one clock: update model from the inputs held over the edge, compare at negedge
  task automatic tick();
    int v, hit;
    @(posedge clk);
    if (!rst_n) begin
      m_tx = ONES; m_acc = ONES; m_pend = 0; m_en = 0; cand_q.delete();
    end else begin
      hit = 0;
      v = int'(rx_slot);
      if (slot_stb) begin
        if (v == m_acc) cand_q.delete();
        else if (cand_q.size() > 0 && cand_q[0] == v) begin hit = 1; cand_q.delete(); end
        else begin cand_q.delete(); cand_q.push_back(v); end
      end
      if (host_we && host_addr == 2'd0) m_tx = int'(host_wdata) % (ONES + 1);
      if (host_we && host_addr == 2'd2) begin
        m_en = int'(host_wdata[0]);
        if (host_wdata[1]) m_pend = 0;
      end
      if (hit) begin m_pend = 1; m_acc = v; end
    end
    @(negedge clk);
    check({cur_req, " model tx_slot"}, int'(tx_slot), m_tx);
    check({cur_req, " model irq"}, int'(irq), m_pend & m_en);
    check({cur_req, " model rdata"}, int'(host_rdata), model_read(int'(host_addr)));
  endtask

  task automatic hwrite(int a, int d);
    host_we = 1'b1; host_addr = 2'(a); host_wdata = DATA_W'(d);
    tick();
    host_we = 1'b0;
  endtask

  function automatic int peek(int a);
    host_addr = 2'(a);
    return 0;
  endfunction

  task automatic read_check(string req, int a, int exp);
    int dummy;
    dummy = peek(a);
    #0.1;
    check(req, int'(host_rdata), exp);
  endtask

  task automatic frame(int v);
    slot_stb = 1'b1; rx_slot = CODE_W'(v);
    tick();
    slot_stb = 1'b0;
    repeat (3) tick();
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    read_check("R1 tx reg", 0, ONES);
    read_check("R1 rx reg", 1, ONES);
    read_check("R1 ctrl reg", 2, 0);
    check("R1 tx_slot", int'(tx_slot), ONES);
    check("R1 irq", int'(irq), 0);

    cur_req = "R2";
    hwrite(2, 1);
    hwrite(0, 'h15);
    check("R2 tx_slot after write", int'(tx_slot), 'h15);
    read_check("R2 tx readback", 0, 'h15);

    cur_req = "R4";
    frame(ONES); frame(ONES);
    frame('h0A); frame(ONES);
    read_check("R4 single frame ignored", 1, ONES);
    check("R4 no irq", int'(irq), 0);

    cur_req = "R5";
    frame('h0A);
    slot_stb = 1'b1; rx_slot = 6'h0A;
    tick();
    slot_stb = 1'b0;
    read_check("R5 accepted next cycle", 1, 'h0A);
    check("R5 irq set", int'(irq), 1);
    repeat (3) tick();
    check("R3 tx_slot held over frames", int'(tx_slot), 'h15);

    cur_req = "R9";
    hwrite(2, 1);
    check("R9 write zero keeps pending", int'(irq), 1);
    frame('h33); frame('h33);
    read_check("R9 second accept", 1, 'h33);
    hwrite(2, 3);
    check("R9 clear by write one", int'(irq), 0);

    cur_req = "R6";
    frame('h11); frame('h22); frame('h22);
    read_check("R6 replaced candidate accepted", 1, 'h22);
    hwrite(2, 3);

    cur_req = "R7";
    frame('h05); frame('h22); frame('h05);
    read_check("R7 equal frame drops candidate", 1, 'h22);
    check("R7 no irq", int'(irq), 0);
    frame('h22);
    check("R7 equal value no irq", int'(irq), 0);
    frame('h05); frame('h05);
    read_check("R7 later accepted", 1, 'h05);
    hwrite(2, 2);

    cur_req = "R8";
    frame('h2A); frame('h2A);
    check("R8 masked irq low", int'(irq), 0);
    read_check("R8 pending visible", 2, 2);
    hwrite(2, 1);
    check("R8 enable raises irq", int'(irq), 1);
    hwrite(2, 3);

    cur_req = "R10";
    frame('h07);
    for (int i = 0; i < 8; i++) begin
      rx_slot = CODE_W'(i * 9);
      tick();
    end
    read_check("R10 unstrobed changes ignored", 1, 'h2A);
    frame('h07);
    read_check("R10 candidate kept across idle", 1, 'h07);

    cur_req = "R9";
    hwrite(2, 3);
    frame('h19);
    host_we = 1'b1; host_addr = 2'd2; host_wdata = 8'h03;
    slot_stb = 1'b1; rx_slot = 6'h19;
    tick();
    host_we = 1'b0; slot_stb = 1'b0;
    check("R9 set wins over clear", int'(irq), 1);
    read_check("R9 pending after race", 2, 3);

    cur_req = "R3";
    hwrite(0, 'h2C);
    frame('h01); frame('h01);
    check("R3 tx_slot unchanged by rx", int'(tx_slot), 'h2C);
    read_check("R3 tx readback", 0, 'h2C);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule